// File: doc/BRIEF.md
# Three-Wire Serial Control Receiver

This block is the write-only slave end of a three-wire microcontroller control bus. The bus has a mode line, a bit clock line and a data line. The block samples all three lines into the system clock domain and assembles 8-bit bytes, least significant bit first. When the mode line is low, a byte is an address byte. When the mode line is high, a byte is a data byte.

An address byte carries a 6-bit device address in its upper six bits and a transfer type in its lower two bits. The block responds only to its own address. Once selected, every following data byte goes to one of two register banks. The transfer type picks the bank. The top two bits of the data byte pick the register within that bank, and the lower six bits carry the value. The selection stays in force until the next address byte arrives.

The registers hold five settings: the system clock ratio, the audio input format, a 6-bit volume code, the de-emphasis choice and the mute bit. They leave the block as plain register outputs in the system clock domain.

Top module: `ctl3w_rx`

## Requirements
- R1: After reset the outputs read clock ratio 2'b10 (256fs), format 3'b000 (I2S), volume 6'b000000, de-emphasis 2'b00 and mute 0.
- R2: Bits are sampled on the rising edge of the control clock, least significant bit first, and a byte has no effect until its eighth bit has arrived.
- R3: An address byte is a byte received while the mode line is low. It selects the block only when bits 7..2 equal 6'b000101.
- R4: An address byte with any other device field deselects the block, and all data bytes are ignored until a matching address byte is received.
- R5: Address bits 1..0 give the transfer type: 2'b00 selects the data bank and 2'b10 selects the status bank. Types 2'b01 and 2'b11 cause all following data bytes to be ignored.
- R6: A selected address and type apply to any number of consecutive data bytes.
- R7: In the status bank, a byte with bits 7..6 = 2'b00 loads the clock ratio from bits 5..4 and the format from bits 3..1. Any other prefix is ignored.
- R8: In the data bank, prefix 2'b00 loads the volume from bits 5..0. Prefix 2'b10 loads de-emphasis from bits 4..3 and mute from bit 2. Prefixes 2'b01 and 2'b11 are ignored.
- R9: A clock ratio code of 2'b11 leaves the clock ratio unchanged. Format codes 3'b101 to 3'b111 leave the format unchanged. The other field carried in the same byte is still written.
- R10: A change of the mode line discards any partially received byte.
- R11: The outputs change only in the cycle after a complete, accepted data byte.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ctl_mode_i | input | 1 | Bus mode line: low for address bytes, high for data bytes |
| ctl_clk_i | input | 1 | Bus bit clock |
| ctl_data_i | input | 1 | Bus serial data |
| clk_ratio_o | output | 2 | Clock ratio code: 00 512fs, 01 384fs, 10 256fs |
| fmt_o | output | 3 | Input format: 000 I2S, 001/010/011 LSB-justified 16/18/20, 100 MSB-justified |
| vol_o | output | 6 | Volume attenuation code |
| deemph_o | output | 2 | De-emphasis: 00 off, 01 32 kHz, 10 44.1 kHz, 11 48 kHz |
| mute_o | output | 1 | Mute enable |

## Verification
The hardest state to reach from the ports is a partial byte that is cut short by a mode change. If the bit counter were not cleared, the stale bits would merge into the next byte.

The bench sends five data bits, drops and raises the mode line, and then sends a full volume byte. Only a correctly discarded fragment gives the expected code. A byte stopped after seven bits is also checked: the outputs must not change until the eighth clock edge. A run of three data bytes after a single address checks that the selection is held.

// File: rtl/ctl3w_pkg.sv
package ctl3w_pkg;
  localparam int unsigned BYTE_W  = 8;
  localparam int unsigned DEV_W   = 6;
  localparam int unsigned CNT_W   = $clog2(BYTE_W);
  localparam logic [DEV_W-1:0] DEV_ADDR = 6'b000101;

  typedef enum logic [1:0] {
    XFER_DATA   = 2'b00,
    XFER_RSVD1  = 2'b01,
    XFER_STATUS = 2'b10,
    XFER_RSVD3  = 2'b11
  } xfer_e;

  typedef struct packed {
    logic [1:0] ratio;
    logic [2:0] fmt;
    logic [5:0] vol;
    logic [1:0] deemph;
    logic       mute;
  } cfg_t;

  localparam cfg_t CFG_RST = '{ratio: 2'b10, fmt: 3'b000, vol: 6'd0, deemph: 2'b00, mute: 1'b0};
endpackage

// File: rtl/ctl3w_sync.sv
module ctl3w_sync #(
  parameter int unsigned WIDTH  = 1,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [STAGES-1:0][WIDTH-1:0] pipe_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pipe_q[0] <= '0;
    else         pipe_q[0] <= d_i;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) pipe_q[s] <= '0;
      else         pipe_q[s] <= pipe_q[s-1];
    end
  end

  assign q_o = pipe_q[STAGES-1];
endmodule

// File: rtl/ctl3w_shifter.sv
module ctl3w_shifter
  import ctl3w_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              mode_i,
  input  logic              sclk_i,
  input  logic              sdat_i,
  output logic              byte_vld_o,
  output logic              byte_mode_o,
  output logic [BYTE_W-1:0] byte_o
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(BYTE_W - 1);

  logic              sclk_q, mode_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [BYTE_W-1:0] sh_q;
  logic [BYTE_W-1:0] sh_nxt;
  logic              rise;

  assign rise   = sclk_i & ~sclk_q;
  assign sh_nxt = {sdat_i, sh_q[BYTE_W-1:1]};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sclk_q      <= 1'b0;
      mode_q      <= 1'b0;
      cnt_q       <= '0;
      sh_q        <= '0;
      byte_vld_o  <= 1'b0;
      byte_mode_o <= 1'b0;
      byte_o      <= '0;
    end else begin
      sclk_q     <= sclk_i;
      mode_q     <= mode_i;
      byte_vld_o <= 1'b0;
      if (mode_i != mode_q) begin
        cnt_q <= '0;  // drop fragment on mode change
      end else if (rise) begin
        sh_q <= sh_nxt;
        if (cnt_q == LAST) begin
          cnt_q       <= '0;
          byte_vld_o  <= 1'b1;
          byte_mode_o <= mode_i;
          byte_o      <= sh_nxt;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/ctl3w_regs.sv
module ctl3w_regs
  import ctl3w_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              byte_vld_i,
  input  logic              byte_mode_i,
  input  logic [BYTE_W-1:0] byte_i,
  output logic              sel_o,
  output cfg_t              cfg_o
);
  xfer_e      xfer_q;
  logic [1:0] prefix;
  logic [5:0] val;

  assign prefix = byte_i[BYTE_W-1:BYTE_W-2];
  assign val    = byte_i[5:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sel_o  <= 1'b0;
      xfer_q <= XFER_DATA;
      cfg_o  <= CFG_RST;
    end else if (byte_vld_i) begin
      if (!byte_mode_i) begin
        sel_o  <= (byte_i[BYTE_W-1:BYTE_W-DEV_W] == DEV_ADDR);
        xfer_q <= xfer_e'(byte_i[1:0]);
      end else if (sel_o) begin
        unique case (xfer_q)
          XFER_DATA: begin
            if (prefix == 2'b00) cfg_o.vol <= val;
            else if (prefix == 2'b10) begin
              cfg_o.deemph <= val[4:3];
              cfg_o.mute   <= val[2];
            end
          end
          XFER_STATUS: begin
            if (prefix == 2'b00) begin
              if (val[5:4] != 2'b11) cfg_o.ratio <= val[5:4];
              if (val[3:1] <= 3'b100) cfg_o.fmt <= val[3:1];
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/ctl3w_rx.sv
module ctl3w_rx
  import ctl3w_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       ctl_mode_i,
  input  logic       ctl_clk_i,
  input  logic       ctl_data_i,
  output logic [1:0] clk_ratio_o,
  output logic [2:0] fmt_o,
  output logic [5:0] vol_o,
  output logic [1:0] deemph_o,
  output logic       mute_o
);
  logic [2:0]        pins_s;
  logic              byte_vld, byte_mode, dev_sel;
  logic [BYTE_W-1:0] byte_w;
  cfg_t              cfg;

  ctl3w_sync #(.WIDTH(3), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({ctl_mode_i, ctl_clk_i, ctl_data_i}),
    .q_o   (pins_s)
  );

  ctl3w_shifter u_shift (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .mode_i     (pins_s[2]),
    .sclk_i     (pins_s[1]),
    .sdat_i     (pins_s[0]),
    .byte_vld_o (byte_vld),
    .byte_mode_o(byte_mode),
    .byte_o     (byte_w)
  );

  ctl3w_regs u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .byte_vld_i (byte_vld),
    .byte_mode_i(byte_mode),
    .byte_i     (byte_w),
    .sel_o      (dev_sel),
    .cfg_o      (cfg)
  );

  assign clk_ratio_o = cfg.ratio;
  assign fmt_o       = cfg.fmt;
  assign vol_o       = cfg.vol;
  assign deemph_o    = cfg.deemph;
  assign mute_o      = cfg.mute;
endmodule

// File: rtl/ctl3w_chk.sv
module ctl3w_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic [13:0] cfg_i,
  input logic        byte_vld_i,
  input logic        byte_mode_i,
  input logic        sel_i
);
  // R9: an invalid ratio code never reaches the outputs
  p_ratio_valid_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_i[13:12] != 2'b11);

  // R9: an invalid format code never reaches the outputs
  p_fmt_valid_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_i[11:9] <= 3'b100);

  // R11: no byte completed, no change
  p_hold_idle_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !byte_vld_i |=> $stable(cfg_i));

  // R3: address bytes never write settings
  p_addr_no_write_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (byte_vld_i && !byte_mode_i) |=> $stable(cfg_i));

  // R4: data bytes while deselected are ignored
  p_desel_ignore_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (byte_vld_i && byte_mode_i && !sel_i) |=> $stable(cfg_i));
endmodule

bind ctl3w_rx ctl3w_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .cfg_i      ({clk_ratio_o, fmt_o, vol_o, deemph_o, mute_o}),
  .byte_vld_i (byte_vld),
  .byte_mode_i(byte_mode),
  .sel_i      (dev_sel)
);

// File: tb/tb_ctl3w_rx.sv
module tb_ctl3w_rx;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic mode = 1'b0, sclk = 1'b0, sdat = 1'b0;
  logic [1:0] ratio;
  logic [2:0] fmt;
  logic [5:0] vol;
  logic [1:0] de;
  logic       mt;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #10 clk = ~clk;

  ctl3w_rx dut (
    .clk_i(clk), .rst_ni(rst_n), .ctl_mode_i(mode), .ctl_clk_i(sclk),
    .ctl_data_i(sdat), .clk_ratio_o(ratio), .fmt_o(fmt), .vol_o(vol),
    .deemph_o(de), .mute_o(mt)
  );

  // {addr, data, expected {ratio,fmt,vol,de,mute}}
  localparam logic [29:0] VEC [13] = '{
    {8'h14, 8'h2A, 14'b10_000_101010_00_0},  // R8 vol, R2 lsb first
    {8'h14, 8'h94, 14'b10_000_101010_10_1},  // R8 de/mute
    {8'h16, 8'h16, 14'b01_011_101010_10_1},  // R7
    {8'h16, 8'h38, 14'b01_100_101010_10_1},  // R9 bad ratio
    {8'h16, 8'h0C, 14'b00_100_101010_10_1},  // R9 bad fmt
    {8'h15, 8'h05, 14'b00_100_101010_10_1},  // R5 type 01
    {8'h17, 8'h3F, 14'b00_100_101010_10_1},  // R5 type 11
    {8'h18, 8'h01, 14'b00_100_101010_10_1},  // R4 wrong addr
    {8'h16, 8'h80, 14'b00_100_101010_10_1},  // R7 prefix 10
    {8'h14, 8'h7F, 14'b00_100_101010_10_1},  // R8 prefix 01
    {8'h14, 8'hC0, 14'b00_100_101010_10_1},  // R8 prefix 11
    {8'h14, 8'h88, 14'b00_100_101010_01_0},  // R8
    {8'h14, 8'h3F, 14'b00_100_111111_01_0}   // R3 match
  };

  function automatic logic [13:0] cur();
    return {ratio, fmt, vol, de, mt};
  endfunction

  task automatic check(input string req, input logic [13:0] exp);
    n_chk++;
    if (cur() !== exp) begin
      n_fail++;
      $display("FAIL %s: got %b expected %b", req, cur(), exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_bit(input logic b);
    sdat = b;
    wait_clk(4);
    sclk = 1'b1;
    wait_clk(4);
    sclk = 1'b0;
  endtask

  task automatic set_mode(input logic m);
    mode = m;
    wait_clk(6);
  endtask

  task automatic send_byte(input logic [7:0] b);
    for (int i = 0; i < 8; i++) send_bit(b[i]);
    wait_clk(8);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    wait_clk(3);
    rst_n = 1'b1;
    wait_clk(3);
    check("R1 reset", 14'b10_000_000000_00_0);

    for (int v = 0; v < 13; v++) begin
      set_mode(1'b0);
      send_byte(VEC[v][29:22]);
      set_mode(1'b1);
      send_byte(VEC[v][21:14]);
      check($sformatf("R5/R7/R8 vector %0d", v), VEC[v][13:0]);
    end

    // R4: still deselected over several bytes, then reselect
    set_mode(1'b0); send_byte(8'h18);
    set_mode(1'b1); send_byte(8'h05); send_byte(8'h90);
    check("R4 deselected", 14'b00_100_111111_01_0);
    set_mode(1'b0); send_byte(8'h14);
    set_mode(1'b1); send_byte(8'h05);
    check("R4 reselect", 14'b00_100_000101_01_0);

    // R6: one address, three data bytes
    set_mode(1'b0); send_byte(8'h14);
    set_mode(1'b1); send_byte(8'h11);
    check("R6 byte1", 14'b00_100_010001_01_0);
    send_byte(8'h90);
    check("R6 byte2", 14'b00_100_010001_10_0);
    send_byte(8'h22);
    check("R6 byte3", 14'b00_100_100010_10_0);

    // R2: seven bits do nothing, eighth commits
    for (int i = 0; i < 7; i++) send_bit(1'b1);
    wait_clk(8);
    check("R2 seven bits", 14'b00_100_100010_10_0);
    send_bit(1'b0);  // byte 0x7F: prefix 01 ignored
    wait_clk(8);
    check("R2 eighth bit prefix01", 14'b00_100_100010_10_0);
    for (int i = 0; i < 7; i++) send_bit(i == 0 || i == 2);
    wait_clk(8);
    check("R2 partial vol", 14'b00_100_100010_10_0);
    send_bit(1'b0);  // byte 0x05
    wait_clk(8);
    check("R2 full vol", 14'b00_100_000101_10_0);

    // R10: fragment then mode toggle is discarded
    for (int i = 0; i < 5; i++) send_bit(1'b1);
    set_mode(1'b0);
    set_mode(1'b1);
    send_byte(8'h09);
    check("R10 fragment dropped", 14'b00_100_001001_10_0);

    // R1: reset restores defaults
    rst_n = 1'b0;
    wait_clk(2);
    check("R1 re-reset", 14'b10_000_000000_00_0);
    rst_n = 1'b1;
    wait_clk(4);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule